// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block is the command front end of a dual-bank NOR flash. It watches the asynchronous-style strobes (chip enable, write enable and output enable), which have already been sampled into its clock domain. It turns each completed bus write into a read-mode change, a status clear, or a program/erase request. For every read it tells the data path where the byte comes from: the array, one of the two identifier codes, or the status register.

An internal engine model stands in for the program/erase sequencer. It stays busy for a configurable number of clock cycles and can be suspended and resumed. While an operation is pending in one bank, reads aimed at the other bank go straight to the array, with no mode command. Reads aimed at the running bank return status. A bank-level lock mask, together with a write-protect input, refuses modifications to locked banks.

The top address bit selects the bank. The status byte seen on `status` is a snapshot taken when a read window opens, so software must toggle the strobe to observe a new value.

Top module: `flash_cmd_fsm`

## Requirements
- R1: Reset (`rst_n` low, asynchronous) aborts any operation. It returns the interface to read-array mode, loads 80h into `status`, and drives `ready` high. While in reset, `rd_src` is 0 (array).
- R2: A bus write is a window in which `ce_n` and `we_n` are low and `oe_n` is high. The window completes when `we_n` or `ce_n` rises, whichever rises first. The address and data acted on are the values held while the window was open, not the values present after it closes.
- R3: `rd_src` encoding is 0 for array, 1 for manufacturer code, 2 for device code and 3 for status. Command FFh selects read array and 70h selects read status. While a setup command awaits its second cycle, reads return status.
- R4: After 90h, a read whose in-bank offset (all address bits below the top one) is zero selects the manufacturer code (`rd_src`=1). Any other offset selects the device code (`rd_src`=2).
- R5: 20h followed by D0h starts an erase in the bank given by the top address bit of the D0h write. `ready` goes low on the clock edge that completes the confirm write and stays low for exactly OP_CYCLES cycles. The interface enters read-status mode.
- R6: 40h followed by any single write starts a program operation in that write's bank, with the same busy timing as R5 and the same switch to read-status mode.
- R7: If the second cycle after 20h is not D0h, no operation starts. Status bits 5 and 4 are both set, and the interface enters read-status mode.
- R8: The live status byte has bit 7 = engine not busy, bit 6 = erase suspended, bits 5/4/1 = erase/program/lock failure, bit 2 = program suspended, and bits 3 and 0 = 0. `status` takes this value only on the cycle a read window opens (`ce_n` and `oe_n` both low after either was high). At all other times it holds.
- R9: Failure bits 5, 4 and 1 are cleared only by command 50h or by reset. Command FFh leaves them set. Command 50h does not change the read mode.
- R10: While an operation is pending (running or suspended), a read whose bank differs from the operation's bank gives `rd_src`=0, whatever the read mode. While the operation runs, a read to its own bank gives `rd_src`=3, even after FFh.
- R11: B0h written with the operation's bank address suspends it. `ready` goes high, status bit 6 (erase) or bit 2 (program) is set, and the cycle count freezes. D0h with that bank address resumes the operation, which then finishes within its remaining cycles. B0h or D0h written with the other bank's address has no effect.
- R12: With `wp_n` low, an erase or program aimed at a bank whose bit in LOCK_MASK is 1 does not start. It sets status bit 1 plus bit 5 (erase) or bit 4 (program). With `wp_n` high, or for an unlocked bank, the operation starts normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset / power-down |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| wp_n | input | 1 | Write protect, active low |
| addr | input | ADDR_W | Bus address; top bit selects the bank |
| din | input | 8 | Command / write data |
| rd_src | output | 2 | Read source select: 0 array, 1 manufacturer ID, 2 device ID, 3 status |
| status | output | 8 | Status byte captured at the opening of the last read window |
| ready | output | 1 | High when the engine is not running (idle or suspended) |

## Verification
The bench builds the block with ADDR_W=8, OP_CYCLES=16 and LOCK_MASK=2'b10. The short busy period lets the bench count the exact cycle on which `ready` returns after a start, and the remaining cycles after a resume. It also leaves room for reads and wrong-bank commands while an operation is still in flight. With bank 1 locked and bank 0 free, the same run covers both a refused and an accepted modification under write protect.

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int         ADDR_W    = 20,
  parameter int         OP_CYCLES = 1000,
  parameter logic [1:0] LOCK_MASK = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [1:0]        rd_src,
  output logic [7:0]        status,
  output logic              ready
);
  localparam int CNT_W = $clog2(OP_CYCLES + 1);
  localparam int MSB   = ADDR_W - 1;

  localparam logic [1:0] SRC_ARR  = 2'd0;
  localparam logic [1:0] SRC_MFR  = 2'd1;
  localparam logic [1:0] SRC_DEV  = 2'd2;
  localparam logic [1:0] SRC_STAT = 2'd3;

  localparam logic [7:0] C_ARRAY = 8'hFF;
  localparam logic [7:0] C_IDENT = 8'h90;
  localparam logic [7:0] C_STAT  = 8'h70;
  localparam logic [7:0] C_CLEAR = 8'h50;
  localparam logic [7:0] C_ERASE = 8'h20;
  localparam logic [7:0] C_PROG  = 8'h40;
  localparam logic [7:0] C_SUSP  = 8'hB0;
  localparam logic [7:0] C_CONF  = 8'hD0;

  typedef enum logic [2:0] {M_ARR, M_ID, M_STAT, M_ERA, M_PRG} mode_t;

  mode_t            mode;
  logic             wr_q, rd_q, lat_bank;
  logic [7:0]       lat_d, stat_q, sr_live;
  logic             op_act, op_susp, op_erase, op_bank;
  logic             err_e, err_p, err_l;
  logic [CNT_W-1:0] cnt;

  logic wr_on, rd_on, rd_start, commit, setup, cmd;
  logic go_erase, go_prog, go_any, bad_conf, lock_hit, start_ok, lock_fail;
  logic do_susp, do_res, do_clr;

  assign wr_on    = !ce_n && !we_n && oe_n;
  assign rd_on    = !ce_n && !oe_n;
  assign rd_start = rd_on && !rd_q;
  assign commit   = wr_q && !wr_on;
  assign setup    = (mode == M_ERA) || (mode == M_PRG);
  assign cmd      = commit && !setup;

  assign go_erase  = commit && (mode == M_ERA) && (lat_d == C_CONF);
  assign bad_conf  = commit && (mode == M_ERA) && (lat_d != C_CONF);
  assign go_prog   = commit && (mode == M_PRG);
  assign go_any    = go_erase || go_prog;
  assign lock_hit  = !wp_n && LOCK_MASK[lat_bank];
  assign start_ok  = go_any && !op_act && !lock_hit;
  assign lock_fail = go_any && !op_act && lock_hit;

  assign do_susp = cmd && (lat_d == C_SUSP) && op_act && !op_susp &&
                   (lat_bank == op_bank) && (cnt != CNT_W'(1));
  assign do_res  = cmd && (lat_d == C_CONF) && op_susp && (lat_bank == op_bank);
  assign do_clr  = cmd && (lat_d == C_CLEAR);

  assign ready   = !(op_act && !op_susp);
  assign sr_live = {ready, op_susp & op_erase, err_e, err_p,
                    1'b0, op_susp & ~op_erase, err_l, 1'b0};
  assign status  = stat_q;

  always_comb begin
    if (op_act && (addr[MSB] != op_bank))
      rd_src = SRC_ARR;
    else if (op_act && !op_susp)
      rd_src = SRC_STAT;
    else begin
      case (mode)
        M_ARR:   rd_src = SRC_ARR;
        M_ID:    rd_src = (addr[MSB-1:0] == '0) ? SRC_MFR : SRC_DEV;
        default: rd_src = SRC_STAT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      lat_bank <= 1'b0;
      lat_d    <= '0;
      stat_q   <= 8'h80;
    end else begin
      wr_q <= wr_on;
      rd_q <= rd_on;
      if (wr_on) begin
        lat_bank <= addr[MSB];
        lat_d    <= din;
      end
      if (rd_start) stat_q <= sr_live;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_act   <= 1'b0;
      op_susp  <= 1'b0;
      op_erase <= 1'b0;
      op_bank  <= 1'b0;
      cnt      <= '0;
    end else begin
      if (start_ok) begin
        op_act   <= 1'b1;
        op_susp  <= 1'b0;
        op_erase <= go_erase;
        op_bank  <= lat_bank;
        cnt      <= CNT_W'(OP_CYCLES);
      end else if (op_act && !op_susp) begin
        if (cnt == CNT_W'(1)) op_act <= 1'b0;
        else                  cnt    <= cnt - CNT_W'(1);
      end
      if (do_susp) op_susp <= 1'b1;
      if (do_res)  op_susp <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_e <= 1'b0;
      err_p <= 1'b0;
      err_l <= 1'b0;
    end else if (do_clr) begin
      err_e <= 1'b0;
      err_p <= 1'b0;
      err_l <= 1'b0;
    end else begin
      if (bad_conf || (lock_fail && go_erase)) err_e <= 1'b1;
      if (bad_conf || (lock_fail && go_prog))  err_p <= 1'b1;
      if (lock_fail)                           err_l <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_ARR;
    end else if (commit && setup) begin
      mode <= M_STAT;
    end else if (cmd) begin
      case (lat_d)
        C_ARRAY: mode <= M_ARR;
        C_IDENT: mode <= M_ID;
        C_STAT:  mode <= M_STAT;
        C_ERASE: mode <= M_ERA;
        C_PROG:  mode <= M_PRG;
        C_SUSP:  if (do_susp) mode <= M_STAT;
        C_CONF:  if (do_res)  mode <= M_STAT;
        default: ;
      endcase
    end
  end

  // R11
  susp_needs_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_susp |-> op_act);

  // R9
  err_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(err_e) || $fell(err_p) || $fell(err_l)) |-> $past(commit && lat_d == C_CLEAR));

  // R5
  start_to_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> (mode == M_STAT));

  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_q) |-> $past(rd_on && !rd_q));

endmodule

// File: tb/flash_cmd_fsm_bench.sv
module flash_cmd_fsm_bench;
  localparam int AW = 8;
  localparam int OP = 16;
  localparam logic [AW-1:0] B0A = 8'h00;
  localparam logic [AW-1:0] B1A = 8'h80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wp_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [1:0] rd_src;
  logic [7:0] status;
  logic ready;
  logic [1:0] got_src;
  logic [7:0] got_st;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_fsm #(.ADDR_W(AW), .OP_CYCLES(OP), .LOCK_MASK(2'b10)) u_flash_cmd_fsm (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .wp_n(wp_n),
    .addr(addr), .din(din), .rd_src(rd_src), .status(status), .ready(ready));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    got_src = rd_src; got_st = status;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset;
    chk("R1 reset ready", {7'd0, ready}, 8'd1);
    chk("R1 reset status", status, 8'h80);
    chk("R1 reset rd_src", {6'd0, rd_src}, 8'd0);
  endtask

  task automatic t_modes;
    wr(B0A, 8'h70); rd(B0A); chk("R3 read status mode", {6'd0, got_src}, 8'd3);
    wr(B0A, 8'hFF); rd(B0A); chk("R3 read array mode", {6'd0, got_src}, 8'd0);
    wr(B0A, 8'h90); rd(B0A); chk("R4 id offset 0", {6'd0, got_src}, 8'd1);
    rd(B1A | 8'h01); chk("R4 id offset 1", {6'd0, got_src}, 8'd2);
    rd(B1A); chk("R4 id offset 0 bank1", {6'd0, got_src}, 8'd1);
    wr(B0A, 8'h40); rd(B0A); chk("R3 setup reads status", {6'd0, got_src}, 8'd3);
    wr(B0A, 8'hFF); wait_ready(got_st[3:0]);
    wr(B0A, 8'hFF);
  endtask

  task automatic t_latch;
    addr = B0A; din = 8'h70; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); @(negedge clk);
    we_n = 1'b1; din = 8'hFF;
    @(negedge clk); ce_n = 1'b1;
    rd(B0A); chk("R2 data latched in window", {6'd0, got_src}, 8'd3);
    addr = B0A; din = 8'hFF; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk); we_n = 1'b1;
    rd(B0A); chk("R2 ce rises first", {6'd0, got_src}, 8'd0);
  endtask

  task automatic t_erase;
    wr(B1A, 8'h20); wr(B1A, 8'hD0);
    chk("R5 busy after confirm", {7'd0, ready}, 8'd0);
    rd(B1A);
    chk("R5 status mode on start", {6'd0, got_src}, 8'd3);
    chk("R8 status busy", got_st, 8'h00);
    repeat (OP - 3) @(negedge clk);
    chk("R5 busy at OP-1", {7'd0, ready}, 8'd0);
    @(negedge clk);
    chk("R5 ready after OP", {7'd0, ready}, 8'd1);
    chk("R8 status held without strobe", status, 8'h00);
    rd(B1A); chk("R8 status done", got_st, 8'h80);
  endtask

  task automatic t_prog;
    int n;
    wr(B0A, 8'h40); wr(B0A | 8'h05, 8'h3C);
    chk("R6 program busy", {7'd0, ready}, 8'd0);
    wait_ready(n);
    chk("R6 program cycles", n[7:0], OP[7:0]);
    rd(B0A); chk("R6 status mode", {6'd0, got_src}, 8'd3);
  endtask

  task automatic t_badconf;
    wr(B0A, 8'h20); wr(B0A, 8'hFF);
    chk("R7 no start", {7'd0, ready}, 8'd1);
    rd(B0A);
    chk("R7 status bits", got_st, 8'hB0);
    chk("R7 status mode", {6'd0, got_src}, 8'd3);
    wr(B0A, 8'hFF); rd(B0A);
    chk("R9 FF keeps errors", got_st, 8'hB0);
    wr(B0A, 8'h50); rd(B0A);
    chk("R9 clear", got_st, 8'h80);
    chk("R9 clear keeps mode", {6'd0, got_src}, 8'd0);
  endtask

  task automatic t_bg;
    int n;
    wr(B0A, 8'h20); wr(B0A, 8'hD0);
    rd(B1A); chk("R10 other bank array", {6'd0, got_src}, 8'd0);
    rd(B0A); chk("R10 busy bank status", {6'd0, got_src}, 8'd3);
    wr(B1A, 8'hFF);
    rd(B0A); chk("R10 busy bank after FF", {6'd0, got_src}, 8'd3);
    rd(B1A); chk("R10 other bank after FF", {6'd0, got_src}, 8'd0);
    wait_ready(n);
    rd(B0A); chk("R10 array after done", {6'd0, got_src}, 8'd0);
  endtask

  task automatic t_susp;
    int n;
    wr(B1A, 8'h20); wr(B1A, 8'hD0);
    wr(B0A, 8'hB0);
    chk("R11 wrong bank suspend ignored", {7'd0, ready}, 8'd0);
    wr(B1A, 8'hB0);
    chk("R11 suspended ready", {7'd0, ready}, 8'd1);
    repeat (3 * OP) @(negedge clk);
    rd(B1A);
    chk("R11 erase suspended status", got_st, 8'hC0);
    wr(B0A, 8'hFF); rd(B0A);
    chk("R11 other bank array while suspended", {6'd0, got_src}, 8'd0);
    wr(B0A, 8'hD0);
    chk("R11 wrong bank resume ignored", {7'd0, ready}, 8'd1);
    wr(B1A, 8'hD0);
    chk("R11 resumed busy", {7'd0, ready}, 8'd0);
    wait_ready(n);
    chk("R11 resume finishes in time", {7'd0, (n > 0 && n < OP)}, 8'd1);
    rd(B1A); chk("R11 done after resume", got_st, 8'h80);
    wr(B0A, 8'h40); wr(B0A, 8'h55); wr(B0A, 8'hB0);
    rd(B0A); chk("R11 program suspended status", got_st, 8'h84);
    wr(B0A, 8'hD0); wait_ready(n);
    rd(B0A); chk("R11 program done", got_st, 8'h80);
  endtask

  task automatic t_lock;
    int n;
    wp_n = 1'b0;
    wr(B1A, 8'h20); wr(B1A, 8'hD0);
    chk("R12 locked erase refused", {7'd0, ready}, 8'd1);
    rd(B1A); chk("R12 lock erase status", got_st, 8'hA2);
    wr(B1A, 8'h50);
    wr(B1A, 8'h40); wr(B1A, 8'h11);
    rd(B1A); chk("R12 lock program status", got_st, 8'h92);
    wr(B1A, 8'h50);
    wr(B0A, 8'h40); wr(B0A, 8'h22);
    chk("R12 unlocked bank starts", {7'd0, ready}, 8'd0);
    wait_ready(n);
    wp_n = 1'b1;
    wr(B1A, 8'h20); wr(B1A, 8'hD0);
    chk("R12 wp high starts", {7'd0, ready}, 8'd0);
    wait_ready(n);
    rd(B1A); chk("R12 clean status", got_st, 8'h80);
  endtask

  task automatic t_abort;
    wr(B0A, 8'h20); wr(B0A, 8'h00);
    wr(B0A, 8'h20); wr(B0A, 8'hD0);
    chk("R1 busy before abort", {7'd0, ready}, 8'd0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 abort ready", {7'd0, ready}, 8'd1);
    chk("R1 abort status", status, 8'h80);
    chk("R1 abort rd_src", {6'd0, rd_src}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(B0A);
    chk("R1 errors gone after reset", got_st, 8'h80);
    chk("R1 array mode after reset", {6'd0, got_src}, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_latch();
    t_erase();
    t_prog();
    t_badconf();
    t_bg();
    t_susp();
    t_lock();
    t_abort();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule